// File: doc/BRIEF.md
# Buffered Compare PWM Timer Channel

This block is one channel of an up-counting timer that drives a single pulse-width-modulated pin. A period register sets where the counter wraps back to zero and where the pin is driven low. A rise register sets where the pin is driven high. A shadow register stands behind the rise register. Each time the rise register matches, the shadow value moves into it on the same clock edge that raises the pin. Software can therefore stage the next rising-edge position at any time during a period, and the new value never applies part-way through a period.

The counter advances only on clock edges where the count-enable input is high, so a divider outside the block can set the counting rate. Software loads the three registers through a simple write port with an address, data and a write strobe. Two single-cycle status outputs mark the cycle in which each kind of match takes effect. A count output shows the present counter value.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset the counter, the pin, both status pulses and all three registers are 0.
- R2: On an edge with `cnt_en` high and no period match, the counter goes up by one and wraps from all-ones to 0. On an edge with `cnt_en` low the counter, the pin and the registers other than written ones keep their values.
- R3: On an enabled edge where the counter equals the period register (address 1), the counter becomes 0.
- R4: On an enabled edge where the counter equals the rise register (address 0) and not the period register, the pin becomes 1.
- R5: On an enabled edge where the counter equals the period register, the pin becomes 0, even when the rise register matches in the same cycle.
- R6: On every enabled edge where the counter equals the rise register, the shadow register (address 2) is copied into the rise register. The rise value used for the next period is the shadow value that held at that edge.
- R7: A write to the shadow register leaves the active rise value unchanged until the next rise match. A write to the rise register applies from the next cycle.
- R8: `rise_hit` and `fall_hit` are high for exactly the one cycle that follows an enabled edge with a rise match or a period match. This is the same cycle in which the pin and counter show the result of that match.
- R9: A rise-register write on the same edge as a rise match takes the written value, not the shadow value. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 rise, 1 period, 2 shadow, 3 none |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM pin |
| rise_hit | output | 1 | One-cycle pulse after a rise match |
| fall_hit | output | 1 | One-cycle pulse after a period match |
| count_val | output | CNT_W | Present counter value |

## Verification
The bench builds the channel with `CNT_W` set to 8. With that width, a counter whose period value lies below it overflows within 256 ticks, so the wrap from all-ones to zero can be reached. The same width keeps periods of staged shadow values, a rise value equal to the period value, and a rise write placed on the exact match edge within a short run. The arithmetic does not depend on the width, so the default 16-bit build behaves the same way.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic [1:0] {
    SEL_RISE   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Pin level after an enabled edge; the period match dominates (R5)
  function automatic logic pin_next(input logic level, input logic hit_rise,
                                    input logic hit_period);
    if (hit_period)    return 1'b0;
    else if (hit_rise) return 1'b1;
    else               return level;
  endfunction

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             xfer,
  output logic [CNT_W-1:0] rise_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] shadow_q
);

  reg_sel_e sel;
  logic     wr_rise, wr_period, wr_shadow;

  assign sel       = reg_sel_e'(wr_addr);
  assign wr_rise   = wr_en && (sel == SEL_RISE);
  assign wr_period = wr_en && (sel == SEL_PERIOD);
  assign wr_shadow = wr_en && (sel == SEL_SHADOW);

  // Rise register: a direct write beats the shadow transfer (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rise_q <= '0;
    else if (wr_rise) rise_q <= wr_data;
    else if (xfer)    rise_q <= shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= '0;
    else if (wr_period) period_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (wr_shadow) shadow_q <= wr_data;
  end

  // R9: the unused address leaves every register as it was
  a_r9_none_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && !xfer) |=>
      ($stable(rise_q) && $stable(period_q) && $stable(shadow_q)));

  // R7: without a transfer or a rise write, the active rise value holds
  a_r7_rise_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !wr_rise) |=> $stable(rise_q));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                  input logic t, input logic z);
    if (!t)     return c;
    else if (z) return '0;
    else        return c + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_next(cnt_q, tick, clr);
  end

  // R2: no tick, no movement
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_compare_out.sv
module tmr_compare_out
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise_val,
  input  logic [CNT_W-1:0] period_val,
  output logic             hit_rise,
  output logic             hit_period,
  output logic             pin_q,
  output logic             rise_pulse_q,
  output logic             period_pulse_q
);

  assign hit_rise   = tick && (cnt == rise_val);
  assign hit_period = tick && (cnt == period_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q          <= 1'b0;
      rise_pulse_q   <= 1'b0;
      period_pulse_q <= 1'b0;
    end else begin
      pin_q          <= pin_next(pin_q, hit_rise, hit_period);
      rise_pulse_q   <= hit_rise;
      period_pulse_q <= hit_period;
    end
  end

  // R5: a period match always leaves the pin low
  a_r5_period_low: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse_q |-> !pin_q);

  // R4: a lone rise match leaves the pin high
  a_r4_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pulse_q && !period_pulse_q) |-> pin_q);

  // R8: status pulses only follow enabled edges
  a_r8_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pulse_q || period_pulse_q) |-> $past(tick));

endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             rise_hit,
  output logic             fall_hit,
  output logic [CNT_W-1:0] count_val
);

  logic [CNT_W-1:0] rise_q, period_q, shadow_q, cnt_q;
  logic             ev_rise, ev_period;

  tmr_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer(ev_rise), .rise_q(rise_q),
    .period_q(period_q), .shadow_q(shadow_q)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .clr(ev_period), .cnt_q(cnt_q)
  );

  tmr_compare_out #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .cnt(cnt_q),
    .rise_val(rise_q), .period_val(period_q), .hit_rise(ev_rise),
    .hit_period(ev_period), .pin_q(pwm_out), .rise_pulse_q(rise_hit),
    .period_pulse_q(fall_hit)
  );

  assign count_val = cnt_q;

  // R3: the cycle flagged by a period match shows a cleared counter
  a_r3_clear_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    fall_hit |-> (count_val == '0));

  // R6: the cycle flagged by a rise match shows the shadow value moved in
  a_r6_shadow_moved: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_hit && !$past(wr_en && wr_addr == 2'd0)) |-> (rise_q == $past(shadow_q)));

endmodule

// File: tb/cmp_pwm_timer_test.sv
module cmp_pwm_timer_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_out, rise_hit, fall_hit;
  logic [W-1:0] count_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cmp_pwm_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .rise_hit(rise_hit), .fall_hit(fall_hit), .count_val(count_val)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic         pin;
    logic         pr;
    logic         pf;
    logic [W-1:0] cnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // Reference state, kept from the requirements
  logic [W-1:0] m_cnt = '0, m_a = '0, m_b = '0, m_c = '0;
  logic         m_pin = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic we, input logic [1:0] ad,
                      input logic [W-1:0] d, input string tag);
    logic hr, hp;
    exp_t e;
    @(negedge clk);
    cnt_en = en; wr_en = we; wr_addr = ad; wr_data = d;
    hr = en && (m_cnt == m_a);
    hp = en && (m_cnt == m_b);
    if (en) m_cnt = hp ? '0 : W'(m_cnt + 1);
    m_pin = hp ? 1'b0 : (hr ? 1'b1 : m_pin);
    if (we && ad == 2'd0)      m_a = d;
    else if (hr)               m_a = m_c;
    if (we && ad == 2'd1) m_b = d;
    if (we && ad == 2'd2) m_c = d;
    e.pin = m_pin; e.pr = hr; e.pf = hp; e.cnt = m_cnt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, '0, tag);
  endtask

  // Monitor: compares each result just after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "count", count_val, e.cnt);
        check(t, "pin", pwm_out, e.pin);
        check(t, "rise_hit", rise_hit, e.pr);
        check(t, "fall_hit", fall_hit, e.pf);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "count", count_val, 0);
    check("R1", "pin", pwm_out, 0);
    check("R1", "rise_hit", rise_hit, 0);
    check("R1", "fall_hit", fall_hit, 0);
    rst_n = 1'b1;

    // Setup with counting stopped (R2 hold)
    step(1'b0, 1'b1, 2'd1, W'(20), "R2 hold");
    step(1'b0, 1'b1, 2'd0, W'(5),  "R2 hold");
    step(1'b0, 1'b1, 2'd2, W'(5),  "R2 hold");
    run(45, "R3 R4 R5 R8");

    // Stage shadow values mid-period
    step(1'b1, 1'b1, 2'd2, W'(9), "R6 R7");
    run(25, "R6 R7");
    step(1'b1, 1'b1, 2'd2, W'(14), "R6");
    run(25, "R6");

    // Irregular enable pattern
    for (int i = 0; i < 30; i++) step(i % 3 != 0, 1'b0, 2'd0, '0, "R2");

    // Direct rise write applies at once
    step(1'b1, 1'b1, 2'd0, W'(17), "R7");
    run(25, "R7");

    // Rise write on the very edge of a rise match
    while (m_cnt != m_a) step(1'b1, 1'b0, 2'd0, '0, "R9");
    step(1'b1, 1'b1, 2'd0, W'(11), "R9");
    run(25, "R9");

    // Unused address
    step(1'b1, 1'b1, 2'd3, W'(0), "R9");
    run(25, "R9");

    // Rise and period equal
    step(1'b1, 1'b1, 2'd1, W'(10), "R5");
    step(1'b1, 1'b1, 2'd0, W'(10), "R5");
    step(1'b1, 1'b1, 2'd2, W'(10), "R5");
    run(280, "R5");

    // Overflow wrap: lower the period below the running count
    step(1'b1, 1'b1, 2'd1, W'(40), "R2 wrap");
    while (m_cnt != W'(30)) step(1'b1, 1'b0, 2'd0, '0, "R2 wrap");
    step(1'b1, 1'b1, 2'd1, W'(10), "R2 wrap");
    run(260, "R2 wrap");

    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule